// File: doc/BRIEF.md
# Random Word Generator Peripheral

This block is a register-mapped random word source for a simple 32-bit bus with a byte address, a write strobe, a read strobe, write data and read data. Software programs a control register to start the generator, pick the word rate and set up the jitter clock path. It can load a warm-up count that has to run out before any output is kept. It then pulls 32-bit words one at a time through a data register that pops a word queue. A 32-bit linear feedback shift register stands in for the ring oscillators, so the block can be synthesized and checked cycle by cycle.

The current number of queued words sits in the top byte of the status register. The low twenty bits of that register show the warm-up count that is left. An interrupt line is raised while the queue holds at least a programmable number of words, unless it is masked. A jitter-clock enable output reflects the selected clock source. When the divided bus clock is selected, that output pulses once per programmed division period.

Top module: `rbg_periph`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0, the threshold register reads 16, the interrupt-off register reads 0, and both `irq` and `jitter_en` are low.
- R2: Word index is `bus_addr[4:2]`: 0 control, 1 status, 2 data, 3 threshold, 4 interrupt-off. Control keeps bits 0 (run), 1 (fast), 4 (bypass select), 5 (divided source), 15:8 (divider) and 27:16 (two 6-bit oscillator-off masks, a set bit turns that oscillator off), so writing all ones reads back 0x0FFFFF33. Threshold keeps 5 bits and interrupt-off keeps 1 bit.
- R3: With run set, fast clear and no warm-up left, the first word is queued 32 clock edges after the enabling write edge, and then one more every 32 edges. The queued count is reported in status bits 31:24.
- R4: With fast set the period is 16 edges instead of 32.
- R5: Writing the status register loads bits 19:0 as the warm-up count. While it is nonzero and the generator runs, it drops by one per cycle and no word is queued. The first word follows W+P edges after the enabling write, where W is the count and P the period. Status bits 19:0 read the remaining count.
- R6: A read strobe on the data register returns the oldest word and removes it from the queue. Generated words are nonzero, and two words read one after the other differ.
- R7: A data read with an empty queue returns 0 and leaves the count at 0.
- R8: Clearing run stops generation. The words already queued stay and keep their count.
- R9: The queue holds at most 16 words. Words produced while it is full are dropped, and the count stays 16.
- R10: `irq` is high exactly when the queued count is at or above the threshold and interrupt-off bit 0 is clear.
- R11: With bypass select clear, `jitter_en` is 0. With bypass select set and the divided source clear, it is 1 every cycle. With both set, it is a one-cycle pulse every 2*(divider+1) cycles.
- R12: When all twelve oscillator-off bits are set, no word is produced even though run is set. Clearing any one of them resumes production.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and generator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Byte address, word index in bits 4:2 |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; pops the queue at the data register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, valid in the same cycle |
| jitter_en | output | 1 | Jitter clock enable of the selected source |
| irq | output | 1 | Queue-level interrupt |

## Verification
The bench times the first word to the exact edge in both rates and after a warm-up load. A design off by one register would show the count a cycle early or late, and one that queues during warm-up would show words too soon. It fills the queue past capacity, where a design without a full guard would wrap its count. It also reads an empty queue, where a careless pop would underflow the count to 31 or return stale data. The bench counts divided jitter pulses over a fixed window, which catches a divider off by one step. It sets every oscillator-off bit, which must stall a running generator.

// File: rtl/rbg_pkg.sv
package rbg_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned THR_W  = 5;
    localparam int unsigned WARM_W = 20;
    localparam int unsigned OSC_N  = 6;
    localparam int unsigned DIV_W  = 8;

    localparam int unsigned IDX_CTRL = 0;
    localparam int unsigned IDX_STAT = 1;
    localparam int unsigned IDX_DATA = 2;
    localparam int unsigned IDX_THR  = 3;
    localparam int unsigned IDX_IOFF = 4;

    localparam logic [THR_W-1:0] THR_RESET = THR_W'(16);

    typedef struct packed {
        logic [OSC_N-1:0] osc_off_b;
        logic [OSC_N-1:0] osc_off_a;
        logic [DIV_W-1:0] div;
        logic             byp_src;
        logic             byp_sel;
        logic             fast;
        logic             run;
    } ctrl_t;

    function automatic logic [WORD_W-1:0] lfsr_step(input logic [WORD_W-1:0] s);
        return s[0] ? ((s >> 1) ^ 32'hA300_0000) : (s >> 1);
    endfunction

endpackage

// File: rtl/rbg_bitgen.sv
module rbg_bitgen
    import rbg_pkg::*;
#(
    parameter int unsigned SLOW_PERIOD = 32,
    parameter int unsigned FAST_PERIOD = 16,
    parameter logic [WORD_W-1:0] SEED = 32'h1D87_2B41
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              fast,
    input  logic              osc_dead,
    input  logic              warm_load,
    input  logic [WARM_W-1:0] warm_val,
    output logic [WARM_W-1:0] warm,
    output logic              word_vld,
    output logic [WORD_W-1:0] word
);

    localparam int unsigned TICK_W = $clog2(SLOW_PERIOD);

    typedef struct packed {
        logic [WORD_W-1:0] lfsr;
        logic [WARM_W-1:0] warm;
        logic [TICK_W-1:0] tick;
    } gen_t;

    gen_t st_d, st_q;
    logic              active;
    logic [TICK_W-1:0] tick_last;

    always_comb begin
        st_d      = st_q;
        word_vld  = 1'b0;
        active    = run && !osc_dead;
        tick_last = fast ? TICK_W'(FAST_PERIOD - 1) : TICK_W'(SLOW_PERIOD - 1);
        if (warm_load) begin
            st_d.warm = warm_val;
            st_d.tick = '0;
        end else if (active) begin
            st_d.lfsr = lfsr_step(st_q.lfsr);
            if (st_q.warm != '0) begin
                st_d.warm = st_q.warm - 1'b1;
            end else if (st_q.tick >= tick_last) begin
                st_d.tick = '0;
                word_vld  = 1'b1;
            end else begin
                st_d.tick = st_q.tick + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{lfsr: SEED, warm: '0, tick: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign warm = st_q.warm;
    assign word = st_q.lfsr;

endmodule

// File: rtl/rbg_fifo.sv
module rbg_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 32,
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ptr_t;

    ptr_t st_d, st_q;
    logic push_ok, pop_ok;
    logic [WIDTH-1:0] mem_q [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        push_ok = push && (st_q.cnt < CNT_W'(DEPTH));
        pop_ok  = pop && (st_q.cnt != '0);
        if (push_ok) st_d.wr = bump(st_q.wr);
        if (pop_ok)  st_d.rd = bump(st_q.rd);
        case ({push_ok, pop_ok})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wr] <= wdata;
    end

    assign head  = mem_q[st_q.rd];
    assign count = st_q.cnt;

endmodule

// File: rtl/rbg_jdiv.sv
module rbg_jdiv
    import rbg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byp_sel,
    input  logic             byp_src,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    localparam int unsigned CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] lim;
    logic             divided;

    always_comb begin
        lim     = {div, 1'b1};
        divided = byp_sel && byp_src;
        if (!divided)          cnt_d = '0;
        else if (cnt_q >= lim) cnt_d = '0;
        else                   cnt_d = cnt_q + 1'b1;
        tick = byp_sel && (!byp_src || (cnt_q >= lim));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/rbg_periph.sv
module rbg_periph
    import rbg_pkg::*;
#(
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned DEPTH       = 16,
    parameter int unsigned SLOW_PERIOD = 32,
    parameter int unsigned FAST_PERIOD = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              jitter_en,
    output logic              irq
);

    localparam int unsigned IDX_W = ADDR_W - 2;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        ctrl_t            ctrl;
        logic [THR_W-1:0] thr;
        logic             irq_off;
    } regs_t;

    regs_t             rg_d, rg_q;
    logic [IDX_W-1:0]  reg_idx;
    logic              warm_load;
    logic [WARM_W-1:0] warm_cur;
    logic              word_vld;
    logic [WORD_W-1:0] word;
    logic              data_pop;
    logic [WORD_W-1:0] fifo_head;
    logic [CNT_W-1:0]  fifo_cnt;
    logic              gen_run;
    logic              osc_dead;
    logic              irq_off;
    logic              unused_bits;

    assign reg_idx     = bus_addr[ADDR_W-1:2];
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:28]};

    always_comb begin
        rg_d      = rg_q;
        warm_load = 1'b0;
        if (bus_we) begin
            if (reg_idx == IDX_W'(IDX_CTRL)) begin
                rg_d.ctrl.osc_off_b = bus_wdata[27:22];
                rg_d.ctrl.osc_off_a = bus_wdata[21:16];
                rg_d.ctrl.div       = bus_wdata[15:8];
                rg_d.ctrl.byp_src   = bus_wdata[5];
                rg_d.ctrl.byp_sel   = bus_wdata[4];
                rg_d.ctrl.fast      = bus_wdata[1];
                rg_d.ctrl.run       = bus_wdata[0];
            end
            if (reg_idx == IDX_W'(IDX_STAT)) warm_load = 1'b1;
            if (reg_idx == IDX_W'(IDX_THR))  rg_d.thr = bus_wdata[THR_W-1:0];
            if (reg_idx == IDX_W'(IDX_IOFF)) rg_d.irq_off = bus_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '{ctrl: '0, thr: THR_RESET, irq_off: 1'b0};
        end else begin
            rg_q <= rg_d;
        end
    end

    assign gen_run  = rg_q.ctrl.run;
    assign osc_dead = &{rg_q.ctrl.osc_off_b, rg_q.ctrl.osc_off_a};
    assign irq_off  = rg_q.irq_off;
    assign data_pop = bus_re && (reg_idx == IDX_W'(IDX_DATA));

    rbg_bitgen #(
        .SLOW_PERIOD(SLOW_PERIOD),
        .FAST_PERIOD(FAST_PERIOD)
    ) i_bitgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (gen_run),
        .fast     (rg_q.ctrl.fast),
        .osc_dead (osc_dead),
        .warm_load(warm_load),
        .warm_val (bus_wdata[WARM_W-1:0]),
        .warm     (warm_cur),
        .word_vld (word_vld),
        .word     (word)
    );

    rbg_fifo #(
        .DEPTH(DEPTH),
        .WIDTH(WORD_W)
    ) i_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (word_vld),
        .wdata(word),
        .pop  (data_pop),
        .head (fifo_head),
        .count(fifo_cnt)
    );

    rbg_jdiv i_jdiv (
        .clk    (clk),
        .rst_n  (rst_n),
        .byp_sel(rg_q.ctrl.byp_sel),
        .byp_src(rg_q.ctrl.byp_src),
        .div    (rg_q.ctrl.div),
        .tick   (jitter_en)
    );

    always_comb begin
        bus_rdata = '0;
        if (reg_idx == IDX_W'(IDX_CTRL)) begin
            bus_rdata[27:22] = rg_q.ctrl.osc_off_b;
            bus_rdata[21:16] = rg_q.ctrl.osc_off_a;
            bus_rdata[15:8]  = rg_q.ctrl.div;
            bus_rdata[5]     = rg_q.ctrl.byp_src;
            bus_rdata[4]     = rg_q.ctrl.byp_sel;
            bus_rdata[1]     = rg_q.ctrl.fast;
            bus_rdata[0]     = rg_q.ctrl.run;
        end
        if (reg_idx == IDX_W'(IDX_STAT)) begin
            bus_rdata[31:24]       = 8'(fifo_cnt);
            bus_rdata[WARM_W-1:0]  = warm_cur;
        end
        if (reg_idx == IDX_W'(IDX_DATA)) begin
            bus_rdata = (fifo_cnt != '0) ? fifo_head : '0;
        end
        if (reg_idx == IDX_W'(IDX_THR))  bus_rdata[THR_W-1:0] = rg_q.thr;
        if (reg_idx == IDX_W'(IDX_IOFF)) bus_rdata[0] = rg_q.irq_off;
    end

    assign irq = (8'(fifo_cnt) >= 8'(rg_q.thr)) && !rg_q.irq_off;

endmodule

// File: rtl/rbg_periph_chk.sv
module rbg_periph_chk #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             word_vld,
    input logic [19:0]      warm_cur,
    input logic [CNT_W-1:0] fifo_cnt,
    input logic             data_pop,
    input logic             gen_run,
    input logic             osc_dead,
    input logic             irq_off,
    input logic             irq
);

    assert_no_back_to_back_R3: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);

    assert_warm_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_cur != '0) |-> !word_vld);

    assert_pop_drops_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (data_pop && fifo_cnt != '0 && !word_vld) |=> fifo_cnt == CNT_W'($past(fifo_cnt) - 1'b1));

    assert_empty_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_pop && fifo_cnt == '0 && !word_vld) |=> fifo_cnt == '0);

    assert_stop_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_run && !data_pop) |=> $stable(fifo_cnt));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(DEPTH));

    assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_off |-> !irq);

    assert_dead_osc_R12: assert property (@(posedge clk) disable iff (!rst_n)
        osc_dead |-> !word_vld);

endmodule

bind rbg_periph rbg_periph_chk #(
    .DEPTH(DEPTH),
    .CNT_W(CNT_W)
) i_rbg_periph_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .word_vld(word_vld),
    .warm_cur(warm_cur),
    .fifo_cnt(fifo_cnt),
    .data_pop(data_pop),
    .gen_run (gen_run),
    .osc_dead(osc_dead),
    .irq_off (irq_off),
    .irq     (irq)
);

// File: tb/test_rbg_periph.sv
module test_rbg_periph;

    localparam logic [4:0] A_CTRL = 5'h00;
    localparam logic [4:0] A_STAT = 5'h04;
    localparam logic [4:0] A_DATA = 5'h08;
    localparam logic [4:0] A_THR  = 5'h0C;
    localparam logic [4:0] A_IOFF = 5'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        jitter_en;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    rbg_periph i_rbg_periph (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_we   (bus_we),
        .bus_re   (bus_re),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .jitter_en(jitter_en),
        .irq      (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a; bus_re = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic peek(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_of(output logic [31:0] c);
        logic [31:0] s;
        peek(A_STAT, s);
        c = {24'h0, s[31:24]};
    endtask

    task automatic t_reset();
        logic [31:0] d;
        peek(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
        peek(A_STAT, d); chk("R1 status", d, 32'h0);
        peek(A_THR, d);  chk("R1 threshold", d, 32'd16);
        peek(A_IOFF, d); chk("R1 irq off", d, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        chk("R1 jitter", {31'h0, jitter_en}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(A_CTRL, 32'hFFFF_FFFF);
        peek(A_CTRL, d); chk("R2 ctrl mask", d, 32'h0FFF_FF33);
        wr(A_THR, 32'hFFFF_FFFF);
        peek(A_THR, d);  chk("R2 threshold width", d, 32'h1F);
        wr(A_IOFF, 32'hFFFF_FFFF);
        peek(A_IOFF, d); chk("R2 irq off width", d, 32'h1);
        do_reset();
    endtask

    task automatic t_slow();
        logic [31:0] c;
        wr(A_CTRL, 32'h1);
        wait_cyc(31); count_of(c); chk("R3 before first word", c, 0);
        wait_cyc(1);  count_of(c); chk("R3 first word", c, 1);
        wait_cyc(32); count_of(c); chk("R3 second word", c, 2);
        do_reset();
    endtask

    task automatic t_fast();
        logic [31:0] c;
        wr(A_CTRL, 32'h3);
        wait_cyc(15); count_of(c); chk("R4 before first word", c, 0);
        wait_cyc(1);  count_of(c); chk("R4 first word", c, 1);
        do_reset();
    endtask

    task automatic t_warm();
        logic [31:0] c, s;
        wr(A_STAT, 32'd40);
        peek(A_STAT, s); chk("R5 warm load", {12'h0, s[19:0]}, 32'd40);
        wr(A_CTRL, 32'h1);
        wait_cyc(10);
        peek(A_STAT, s); chk("R5 warm drains", {12'h0, s[19:0]}, 32'd30);
        wait_cyc(61); count_of(c); chk("R5 held by warm-up", c, 0);
        wait_cyc(1);  count_of(c); chk("R5 first word after warm-up", c, 1);
        peek(A_STAT, s); chk("R5 warm at zero", {12'h0, s[19:0]}, 32'd0);
        do_reset();
    endtask

    task automatic t_pop_hold();
        logic [31:0] c, w1, w2;
        wr(A_CTRL, 32'h3);
        wait_cyc(48);
        wr(A_CTRL, 32'h0);
        count_of(c); chk("R8 count at stop", c, 3);
        wait_cyc(100);
        count_of(c); chk("R8 words kept", c, 3);
        rd(A_DATA, w1);
        count_of(c); chk("R6 pop count", c, 2);
        chk("R6 word nonzero", {31'h0, w1 != 0}, 32'h1);
        rd(A_DATA, w2);
        count_of(c); chk("R6 second pop count", c, 1);
        chk("R6 words differ", {31'h0, w1 != w2}, 32'h1);
        do_reset();
    endtask

    task automatic t_empty();
        logic [31:0] c, d;
        rd(A_DATA, d);
        chk("R7 empty read data", d, 0);
        count_of(c); chk("R7 empty read count", c, 0);
        do_reset();
    endtask

    task automatic t_full_irq();
        logic [31:0] c;
        chk("R10 irq low when empty", {31'h0, irq}, 0);
        wr(A_CTRL, 32'h3);
        wait_cyc(320);
        count_of(c); chk("R9 full count", c, 16);
        chk("R10 irq at threshold", {31'h0, irq}, 1);
        wr(A_IOFF, 32'h1);
        chk("R10 irq masked", {31'h0, irq}, 0);
        wr(A_IOFF, 32'h0);
        wr(A_THR, 32'd17);
        chk("R10 irq below threshold", {31'h0, irq}, 0);
        wr(A_THR, 32'd5);
        chk("R10 irq above threshold", {31'h0, irq}, 1);
        do_reset();
    endtask

    task automatic t_jitter();
        int n;
        wr(A_CTRL, 32'h0000_0230);
        n = 0;
        for (int i = 0; i < 60; i++) begin
            if (jitter_en) n++;
            @(negedge clk);
        end
        chk("R11 divided pulses", n, 10);
        wr(A_CTRL, 32'h0000_0010);
        n = 0;
        for (int i = 0; i < 10; i++) begin
            if (jitter_en) n++;
            @(negedge clk);
        end
        chk("R11 undivided source", n, 10);
        wr(A_CTRL, 32'h0);
        n = 0;
        for (int i = 0; i < 10; i++) begin
            if (jitter_en) n++;
            @(negedge clk);
        end
        chk("R11 internal path", n, 0);
        do_reset();
    endtask

    task automatic t_osc();
        logic [31:0] c;
        wr(A_CTRL, 32'h0FFF_0001);
        wait_cyc(100);
        count_of(c); chk("R12 all oscillators off", c, 0);
        wr(A_CTRL, 32'h0FFE_0001);
        wait_cyc(32);
        count_of(c); chk("R12 one oscillator on", c, 1);
        do_reset();
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        @(negedge clk);
        do_reset();
        t_reset();
        t_regs();
        t_slow();
        t_fast();
        t_warm();
        t_pop_hold();
        t_empty();
        t_full_irq();
        t_jitter();
        t_osc();
        finish_run();
    end

endmodule